// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer. Its write port and its read port run on two unrelated clocks. Word width and depth are parameters, and the depth must be a power of two. It drives four active-low status outputs: empty, full, almost-empty and almost-full. The two almost thresholds are run-time values. The almost-empty offset `n` and the almost-full offset `m` each live in two halves. The low half holds the lower eight bits of the offset and the high half holds the remaining upper bits. The offset width is log2(depth).

A single offset-select pin, `ld_ni`, is shared by both sides. It chooses between queue traffic and offset-register access. When it is low, writes fill the four offset halves and reads return them. Both use one rotating order: almost-empty low half, almost-empty high half, almost-full low half, almost-full high half, then back to the start. Each side keeps its own position in that rotation.

Pointers cross between domains as Gray code through two-flop synchronizers. As a result each flag is pessimistic: it may lag behind, but it never claims space or data that is not there. Each flag updates only on the clock of its own side.

Top module: `dcfifo_pflag`

## Requirements
- R1: An asynchronous reset (rst_ni low) does the following. It sets empty_no and aempty_no low and full_no and afull_no high. It sets rdata_o to zero and both offsets `n` and `m` to 7. It returns both offset rotations to the almost-empty low half.
- R2: On a wclk rising edge with wen_ni low and ld_ni low, the block writes wdata_i into the offset half the write rotation points at, then advances the rotation. The order is 0 = `n` bits [7:0], 1 = `n` upper bits, 2 = `m` bits [7:0], 3 = `m` upper bits, then back to 0. Each half takes only its own number of low data bits, and the other data bits are ignored.
- R3: On a wclk rising edge with wen_ni low, ld_ni high and full_no high, the block stores wdata_i in the queue. Reads return the words in write order.
- R4: On a wclk edge with wen_ni high, the block changes neither the queue nor the offset registers nor the write rotation, whatever the level of ld_ni.
- R5: On an rclk rising edge with both read enables low and ld_ni low, rdata_o takes the offset half the read rotation points at, zero-extended. The read rotation then advances, using the same four-step order as R2.
- R6: full_no goes low when the write side sees depth unread words. While full_no is low, no word enters the queue. full_no changes only on wclk edges.
- R7: empty_no goes low when the read side sees zero unread words. While empty_no is low, no word leaves the queue and rdata_o holds. empty_no changes only on rclk edges.
- R8: aempty_no is low when the read side sees `n` or fewer unread words, and high when it sees `n`+1 or more. It updates on rclk.
- R9: afull_no is low when the write side sees at least depth−`m` unread words, and high otherwise. It updates on wclk and uses the `m` value held before that edge.
- R10: The read-side flags count a write done at wclk edge k from the second rclk edge that follows the first rclk edge after k. The write-side flags count a read done at rclk edge j from the third wclk edge that follows j. Successive Gray pointer values differ in at most one bit.
- R11: A read or offset read-back takes place only when both ren_a_ni and ren_b_ni are low. With either one high, the queue, rdata_o and the read rotation are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_ni | input | 1 | Write enable, active low |
| ld_ni | input | 1 | Low selects offset-register access, high selects queue traffic |
| wdata_i | input | DATA_W | Write data or offset half |
| ren_a_ni | input | 1 | First read enable, active low |
| ren_b_ni | input | 1 | Second read enable, active low |
| rdata_o | output | DATA_W | Read data or offset half read-back |
| full_no | output | 1 | Full flag, active low |
| afull_no | output | 1 | Almost-full flag, active low |
| empty_no | output | 1 | Empty flag, active low |
| aempty_no | output | 1 | Almost-empty flag, active low |

## Verification
The bench builds the block with its defaults: DATA_W = 9 and DEPTH = 512. This makes the offsets nine bits wide, so both offset halves are real. The high half is a single bit, so an almost-full offset above 255 and the dropping of unused data bits on load can both be seen. A depth of 512 is large enough for that. It is still small enough that filling to full, overrunning, draining to empty and underrunning each take only a few hundred cycles. The read clock is the inverse of the 125 MHz write clock, which fixes the synchronizer latency. This lets the reference model predict every flag exactly on every edge, including while the flags are in transit.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  typedef enum logic [1:0] {
    OFS_AE_LO = 2'd0,
    OFS_AE_HI = 2'd1,
    OFS_AF_LO = 2'd2,
    OFS_AF_HI = 2'd3
  } ofs_sel_e;

  function automatic ofs_sel_e ofs_step(ofs_sel_e s);
    logic [1:0] t;
    t = s + 2'd1;
    return ofs_sel_e'(t);
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 9
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcfifo_ofs_regs.sv
module dcfifo_ofs_regs
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 9
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] ae_ofs_o,
  output logic [ADDR_W-1:0] af_ofs_o,
  output ofs_sel_e          sel_o
);
  localparam int LO_W = (ADDR_W < 8) ? ADDR_W : 8;
  localparam int HI_W = ADDR_W - LO_W;
  localparam logic [ADDR_W-1:0] OFS_RST = ADDR_W'(7);

  ofs_sel_e        sel_q;
  logic [LO_W-1:0] ae_lo_q, af_lo_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= OFS_AE_LO;
      ae_lo_q <= OFS_RST[LO_W-1:0];
      af_lo_q <= OFS_RST[LO_W-1:0];
    end else if (ld_en_i) begin
      sel_q <= ofs_step(sel_q);
      if (sel_q == OFS_AE_LO) ae_lo_q <= wdata_i[LO_W-1:0];
      if (sel_q == OFS_AF_LO) af_lo_q <= wdata_i[LO_W-1:0];
    end
  end

  // upper halves exist only when the offset is wider than a byte
  if (HI_W > 0) begin : g_hi
    logic [HI_W-1:0] ae_hi_q, af_hi_q;

    always_ff @(posedge wclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ae_hi_q <= OFS_RST[ADDR_W-1:LO_W];
        af_hi_q <= OFS_RST[ADDR_W-1:LO_W];
      end else if (ld_en_i) begin
        if (sel_q == OFS_AE_HI) ae_hi_q <= wdata_i[HI_W-1:0];
        if (sel_q == OFS_AF_HI) af_hi_q <= wdata_i[HI_W-1:0];
      end
    end

    assign ae_ofs_o = {ae_hi_q, ae_lo_q};
    assign af_ofs_o = {af_hi_q, af_lo_q};
  end else begin : g_lo_only
    assign ae_ofs_o = ae_lo_q;
    assign af_ofs_o = af_lo_q;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl #(
  parameter int ADDR_W = 9
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              wen_ni,
  input  logic              ld_ni,
  input  logic [ADDR_W:0]   rgray_i,
  input  logic [ADDR_W-1:0] af_ofs_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W:0]   wptr_o,
  output logic [ADDR_W:0]   wgray_o,
  output logic              full_no,
  output logic              afull_no
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << ADDR_W;

  logic [PW-1:0] wptr_q, wptr_d, wgray_q, rbin, fill;
  logic          full_q, afull_q;

  assign we_o   = !wen_ni && ld_ni && full_q;
  assign wptr_d = wptr_q + PW'(we_o);

  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_i >> i);
  end

  // occupancy after this edge, against a possibly stale read pointer
  assign fill = wptr_d - rbin;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b1;
      afull_q <= 1'b1;
    end else begin
      wptr_q  <= wptr_d;
      wgray_q <= wptr_d ^ (wptr_d >> 1);
      full_q  <= (fill != DEPTH_P);
      afull_q <= ((fill + PW'(af_ofs_i)) < DEPTH_P);
    end
  end

  assign waddr_o  = wptr_q[ADDR_W-1:0];
  assign wptr_o   = wptr_q;
  assign wgray_o  = wgray_q;
  assign full_no  = full_q;
  assign afull_no = afull_q;
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 9
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              ren_a_ni,
  input  logic              ren_b_ni,
  input  logic              ld_ni,
  input  logic [ADDR_W:0]   wgray_i,
  input  logic [ADDR_W-1:0] ae_ofs_i,
  input  logic [ADDR_W-1:0] af_ofs_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rptr_o,
  output logic [ADDR_W:0]   rgray_o,
  output ofs_sel_e          sel_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_no,
  output logic              aempty_no
);
  localparam int PW   = ADDR_W + 1;
  localparam int LO_W = (ADDR_W < 8) ? ADDR_W : 8;

  logic [PW-1:0]     rptr_q, rptr_d, rgray_q, wbin, avail;
  logic              empty_q, aempty_q, both_en, re, ofs_rd;
  ofs_sel_e          sel_q;
  logic [DATA_W-1:0] rdata_q, ofs_part;

  assign both_en = !ren_a_ni && !ren_b_ni;
  assign re      = both_en && ld_ni && empty_q;
  assign ofs_rd  = both_en && !ld_ni;
  assign rptr_d  = rptr_q + PW'(re);

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_i >> i);
  end

  assign avail = wbin - rptr_d;

  always_comb begin
    unique case (sel_q)
      OFS_AE_LO: ofs_part = DATA_W'(ae_ofs_i[LO_W-1:0]);
      OFS_AE_HI: ofs_part = DATA_W'(ae_ofs_i >> LO_W);
      OFS_AF_LO: ofs_part = DATA_W'(af_ofs_i[LO_W-1:0]);
      default:   ofs_part = DATA_W'(af_ofs_i >> LO_W);
    endcase
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b0;
      aempty_q <= 1'b0;
      sel_q    <= OFS_AE_LO;
      rdata_q  <= '0;
    end else begin
      rptr_q   <= rptr_d;
      rgray_q  <= rptr_d ^ (rptr_d >> 1);
      empty_q  <= (avail != '0);
      aempty_q <= (avail > PW'(ae_ofs_i));
      if (re) begin
        rdata_q <= mem_rdata_i;
      end else if (ofs_rd) begin
        rdata_q <= ofs_part;
        sel_q   <= ofs_step(sel_q);
      end
    end
  end

  assign raddr_o   = rptr_q[ADDR_W-1:0];
  assign rptr_o    = rptr_q;
  assign rgray_o   = rgray_q;
  assign sel_o     = sel_q;
  assign rdata_o   = rdata_q;
  assign empty_no  = empty_q;
  assign aempty_no = aempty_q;
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 512
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen_ni,
  input  logic              ld_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_a_ni,
  input  logic              ren_b_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_no,
  output logic              afull_no,
  output logic              empty_no,
  output logic              aempty_no
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PW     = ADDR_W + 1;

  logic [ADDR_W-1:0] ae_ofs, af_ofs, waddr, raddr;
  logic [PW-1:0]     wptr, rptr, wgray, rgray, wgray_r, rgray_w;
  logic [DATA_W-1:0] mem_rdata;
  logic              we;
  ofs_sel_e          wsel, rsel;

  dcfifo_ofs_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ofs (
    .wclk_i   (wclk_i),
    .rst_ni   (rst_ni),
    .ld_en_i  (!wen_ni && !ld_ni),
    .wdata_i  (wdata_i),
    .ae_ofs_o (ae_ofs),
    .af_ofs_o (af_ofs),
    .sel_o    (wsel)
  );

  dcfifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .wclk_i   (wclk_i),
    .rst_ni   (rst_ni),
    .wen_ni   (wen_ni),
    .ld_ni    (ld_ni),
    .rgray_i  (rgray_w),
    .af_ofs_i (af_ofs),
    .we_o     (we),
    .waddr_o  (waddr),
    .wptr_o   (wptr),
    .wgray_o  (wgray),
    .full_no  (full_no),
    .afull_no (afull_no)
  );

  dcfifo_sync #(.W(PW)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_r)
  );

  dcfifo_sync #(.W(PW)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_w)
  );

  dcfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  dcfifo_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .ren_a_ni    (ren_a_ni),
    .ren_b_ni    (ren_b_ni),
    .ld_ni       (ld_ni),
    .wgray_i     (wgray_r),
    .ae_ofs_i    (ae_ofs),
    .af_ofs_i    (af_ofs),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .rptr_o      (rptr),
    .rgray_o     (rgray),
    .sel_o       (rsel),
    .rdata_o     (rdata_o),
    .empty_no    (empty_no),
    .aempty_no   (aempty_no)
  );
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
  parameter int ADDR_W = 9
) (
  input logic            wclk_i,
  input logic            rclk_i,
  input logic            rst_ni,
  input logic            wen_ni,
  input logic            ld_ni,
  input logic            ren_a_ni,
  input logic            ren_b_ni,
  input logic            full_no,
  input logic            afull_no,
  input logic            empty_no,
  input logic            aempty_no,
  input logic [ADDR_W:0] wptr_i,
  input logic [ADDR_W:0] rptr_i,
  input logic [ADDR_W:0] wgray_i,
  input logic [ADDR_W:0] rgray_w_i,
  input logic [1:0]      wsel_i,
  input logic [1:0]      rsel_i
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << ADDR_W;

  logic [PW-1:0] rbin_w;
  always_comb begin
    for (int i = 0; i < PW; i++) rbin_w[i] = ^(rgray_w_i >> i);
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wptr_i)); // R6
  AST_COUNT_BOUND: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wptr_i - rbin_w) <= DEPTH_P); // R6
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && ld_ni) |=> $stable(rptr_i)); // R7
  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no); // R8
  AST_FULL_IMPLIES_AFULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no); // R9
  AST_GRAY_ONE_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_i ^ $past(wgray_i)) <= 1); // R10
  AST_WSEL_ROTATE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wen_ni && !ld_ni) |=> (wsel_i == 2'($past(wsel_i) + 2'd1))); // R2
  AST_WEN_HIGH_IDLE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wen_ni |=> ($stable(wptr_i) && $stable(wsel_i))); // R4
  AST_READ_NEEDS_BOTH: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ren_a_ni || ren_b_ni) |=> ($stable(rptr_i) && $stable(rsel_i))); // R11
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .rst_ni    (rst_ni),
  .wen_ni    (wen_ni),
  .ld_ni     (ld_ni),
  .ren_a_ni  (ren_a_ni),
  .ren_b_ni  (ren_b_ni),
  .full_no   (full_no),
  .afull_no  (afull_no),
  .empty_no  (empty_no),
  .aempty_no (aempty_no),
  .wptr_i    (wptr),
  .rptr_i    (rptr),
  .wgray_i   (wgray),
  .rgray_w_i (rgray_w),
  .wsel_i    (wsel),
  .rsel_i    (rsel)
);

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;
  localparam int DATA_W = 9;
  localparam int DEPTH  = 512;
  localparam int AW     = $clog2(DEPTH);
  localparam int LO_W   = 8;
  localparam int HI_W   = AW - LO_W;
  localparam int MAXT   = 8192;

  logic wclk = 1'b0;
  logic rclk;
  logic rst_n = 1'b0;
  logic wen_n = 1'b1, ld_n = 1'b1, ren_a_n = 1'b1, ren_b_n = 1'b1;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic full_n, afull_n, empty_n, aempty_n;

  always #4 wclk = ~wclk;
  assign rclk = ~wclk;

  dcfifo_pflag #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .wclk_i (wclk), .rclk_i (rclk), .rst_ni (rst_n),
    .wen_ni (wen_n), .ld_ni (ld_n), .wdata_i (wdata),
    .ren_a_ni (ren_a_n), .ren_b_ni (ren_b_n), .rdata_o (rdata),
    .full_no (full_n), .afull_no (afull_n),
    .empty_no (empty_n), .aempty_no (aempty_n)
  );

  // reference model state
  int errors = 0, checks = 0, k = 0;
  int wcnt = 0, rcnt = 0;
  int wr_hist [MAXT];
  int rd_hist [MAXT];
  logic [DATA_W-1:0] q [$];
  logic [AW-1:0] n_m = AW'(7), m_m = AW'(7);
  int wsel_m = 0, rsel_m = 0;
  logic full_m = 1'b1, afull_m = 1'b1, empty_m = 1'b0, aempty_m = 1'b0;
  logic [DATA_W-1:0] rdata_m = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at tick %0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  function automatic int wr_at(int i);
    return (i < 0) ? 0 : wr_hist[i];
  endfunction
  function automatic int rd_at(int i);
    return (i < 0) ? 0 : rd_hist[i];
  endfunction

  function automatic logic [DATA_W-1:0] ofs_part(int s);
    case (s)
      0:       return DATA_W'(n_m[LO_W-1:0]);
      1:       return DATA_W'(n_m >> LO_W);
      2:       return DATA_W'(m_m[LO_W-1:0]);
      default: return DATA_W'(m_m >> LO_W);
    endcase
  endfunction

  // one write edge then one read edge; entered 2 ns before the write edge
  task automatic tick(input logic wn, input logic ldn, input logic [DATA_W-1:0] wd,
                      input logic ran, input logic rbn, input string dtag);
    logic [AW-1:0] m_old;
    int fill, avail;
    wen_n = wn; ld_n = ldn; wdata = wd; ren_a_n = ran; ren_b_n = rbn;
    @(posedge wclk);
    #2;
    m_old = m_m;
    if (!wn) begin
      if (ldn) begin
        if (full_m) begin q.push_back(wd); wcnt++; end
      end else begin
        case (wsel_m)
          0: n_m[LO_W-1:0]  = wd[LO_W-1:0];
          1: n_m[AW-1:LO_W] = wd[HI_W-1:0];
          2: m_m[LO_W-1:0]  = wd[LO_W-1:0];
          default: m_m[AW-1:LO_W] = wd[HI_W-1:0];
        endcase
        wsel_m = (wsel_m + 1) % 4;
      end
    end
    wr_hist[k] = wcnt;
    fill    = wcnt - rd_at(k - 3);
    full_m  = (fill < DEPTH);
    afull_m = ((fill + int'(m_old)) < DEPTH);
    chk("R6/R10 full_no", full_n, full_m);
    chk("R9 afull_no", afull_n, afull_m);
    #4;
    if (!ran && !rbn) begin
      if (ldn) begin
        if (empty_m) begin rdata_m = q.pop_front(); rcnt++; end
      end else begin
        rdata_m = ofs_part(rsel_m);
        rsel_m = (rsel_m + 1) % 4;
      end
    end
    rd_hist[k] = rcnt;
    avail    = wr_at(k - 2) - rcnt;
    empty_m  = (avail > 0);
    aempty_m = (avail > int'(n_m));
    chk("R7/R10 empty_no", empty_n, empty_m);
    chk("R8 aempty_no", aempty_n, aempty_m);
    chk({dtag, " rdata_o"}, rdata, rdata_m);
    k++;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #25;
    chk("R1 empty_no", empty_n, 1'b0);
    chk("R1 aempty_no", aempty_n, 1'b0);
    chk("R1 full_no", full_n, 1'b1);
    chk("R1 afull_no", afull_n, 1'b1);
    chk("R1 rdata_o", rdata, '0);
    #1 rst_n = 1'b1;

    // R1 R5: default offsets read back in rotation order
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R1 R5");
    // R4 R11: wen high with ld low, single read enable: no effect
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 9'h1AA, 1'b0, 1'b1, "R4 R11");
    tick(1'b1, 1'b1, 9'h155, 1'b1, 1'b0, "R4 R11");
    // R2: load offsets, fifth load wraps to the first half
    tick(1'b0, 1'b0, 9'h103, 1'b1, 1'b1, "R2");
    tick(1'b0, 1'b0, 9'h1FE, 1'b1, 1'b1, "R2");
    tick(1'b0, 1'b0, 9'h10A, 1'b1, 1'b1, "R2");
    tick(1'b0, 1'b0, 9'h1FF, 1'b1, 1'b1, "R2");
    tick(1'b0, 1'b0, 9'h004, 1'b1, 1'b1, "R2");
    // R2 R5: read back, fifth read wraps
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R2 R5");
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, '0, 1'b0, 1'b0, "R5");
    // R3 R6: fill past full
    for (int i = 0; i < DEPTH + 8; i++)
      tick(1'b0, 1'b1, DATA_W'(i * 37 + 5), 1'b1, 1'b1, "R3");
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, '0, 1'b1, 1'b1, "R6");
    // R11: one read enable with data present
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, '0, 1'b1, 1'b0, "R11");
    // R3 R7: drain past empty
    for (int i = 0; i < DEPTH + 8; i++) tick(1'b1, 1'b1, '0, 1'b0, 1'b0, "R3 R7");
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, '0, 1'b0, 1'b0, "R7");
    // R3 R8 R9 R10: concurrent traffic, write-heavy then read-heavy
    for (int i = 0; i < 900; i++) begin
      step_lfsr();
      tick(lfsr[0] & lfsr[1], 1'b1, DATA_W'(lfsr[12:4]),
           lfsr[2] | lfsr[3], lfsr[2] | lfsr[3], "R3");
    end
    for (int i = 0; i < 900; i++) begin
      step_lfsr();
      tick(lfsr[0] | lfsr[1], 1'b1, DATA_W'(lfsr[12:4]),
           lfsr[2] & lfsr[3], lfsr[2] & lfsr[3], "R3");
    end
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b1, '0, 1'b0, 1'b0, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule